// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block breaks one vector integer add into a series of scalar element operations. A single `start` pulse captures the element count, three base register numbers and a vector-or-scalar flag for each, and a predicate selector. From the next cycle on, the block walks the element indices one per clock. For each enabled element it presents two read register numbers, adds the returned operands, and drives a write of the sum to the destination register. Optionally it also writes a three-bit sign code into condition field i.

The predicate can be absent, taken from an integer mask register (plain or inverted), or taken from per-field EQ bits of the condition register (plain or inverted). The caller supplies the mask register's value and the EQ bits. A disabled element still takes one cycle but writes nothing. A scalar destination ends the sequence at the first element that is actually written.

Top module: `vec_elem_seq`

## Requirements
- R1: With `vl` = 0 at start, `done` is high in the cycle after the start cycle and no `wr_en` or `cr_we` occurs.
- R2: For element i, a register number whose vector flag is set equals base + i modulo 128. One whose flag is clear equals its base for every element.
- R3: With `pred_sel` = 1, element i is written only when bit i of `int_mask` is 1. A disabled element leaves its destination unchanged.
- R4: With `pred_sel` = 2, element i is written only when bit i of `int_mask` is 0.
- R5: With `pred_sel` = 3, element i is enabled by bit i of `cr_eq` (EQ of condition field 4+i). With `pred_sel` = 4, it is enabled by the inverse of that bit, so an element whose EQ bit is 1 is skipped.
- R6: With `pred_sel` = 0 or 5..7, every element is enabled. An all-ones integer mask gives the same writes, and an all-zero integer mask gives no writes.
- R7: `wr_data` equals `rd_a_data` + `rd_b_data` modulo 2^64, read in the same cycle as `wr_en`.
- R8: When `rc_en` was set at start, each write is joined by `cr_we` with `cr_field` = i and `cr_val` = 3'b100 for a negative sum, 3'b010 for zero, and 3'b001 for positive. When `rc_en` was clear, `cr_we` stays low.
- R9: With a scalar destination, the sequence ends after the first written element, and `done` follows in the next cycle.
- R10: Elements are processed one per cycle, skipped or not. `done` pulses for one cycle, vl+1 cycles after the start cycle when no early stop occurs.
- R11: All instruction inputs and the mask sources are sampled at start. Changes to them, and any `start`, while `busy` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a vector add (ignored while busy) |
| vl | input | 7 | Element count 0..64 |
| dst_base | input | 7 | Destination base register |
| srca_base | input | 7 | First source base register |
| srcb_base | input | 7 | Second source base register |
| dst_vec | input | 1 | Destination steps per element |
| srca_vec | input | 1 | First source steps per element |
| srcb_vec | input | 1 | Second source steps per element |
| pred_sel | input | 3 | 0 none, 1 int mask, 2 inverted int mask, 3 CR EQ, 4 inverted CR EQ |
| rc_en | input | 1 | Record sign code per element |
| int_mask | input | 64 | Value of the integer mask register |
| cr_eq | input | 64 | Bit i = EQ bit of condition field 4+i |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_a_reg | output | 7 | First source register of current element |
| rd_b_reg | output | 7 | Second source register of current element |
| rd_a_data | input | 64 | First operand value |
| rd_b_data | input | 64 | Second operand value |
| wr_en | output | 1 | Write the current element |
| wr_reg | output | 7 | Destination register |
| wr_data | output | 64 | Sum |
| cr_we | output | 1 | Write a condition field |
| cr_field | output | 6 | Condition field index (= element index) |
| cr_val | output | 3 | Sign code |

## Verification
Two things can land in the same cycle: the final enabled element's write together with the decision to stop, and a scalar-destination write that ends the loop early while later elements remain. The bench reaches both through random predicates and scalar destinations mixed with directed cases. It judges them by comparing the whole register and condition-field state after `done`, the write count, and the exact completion cycle against a bench model. Overlapping source and destination ranges also put a write and a dependent read into back-to-back cycles, which the sequential model resolves element by element.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  typedef enum logic [2:0] {
    PRED_NONE    = 3'd0,
    PRED_INT     = 3'd1,
    PRED_INT_INV = 3'd2,
    PRED_CR      = 3'd3,
    PRED_CR_INV  = 3'd4
  } pred_sel_e;

  localparam logic [2:0] CODE_NEG  = 3'b100;
  localparam logic [2:0] CODE_ZERO = 3'b010;
  localparam logic [2:0] CODE_POS  = 3'b001;
endpackage

// File: rtl/vseq_pred_mask.sv
module vseq_pred_mask #(
  parameter int VL_MAX = 64,
  parameter int XLEN   = 64
) (
  input  logic [2:0]        pred_sel,
  input  logic [XLEN-1:0]   int_mask,
  input  logic [VL_MAX-1:0] cr_eq,
  output logic [VL_MAX-1:0] elem_mask
);
  import vseq_pkg::*;

  pred_sel_e sel;
  assign sel = pred_sel_e'(pred_sel);

  always_comb begin
    case (sel)
      PRED_INT:     elem_mask = int_mask[VL_MAX-1:0];
      PRED_INT_INV: elem_mask = ~int_mask[VL_MAX-1:0];
      PRED_CR:      elem_mask = cr_eq;
      PRED_CR_INV:  elem_mask = ~cr_eq;
      default:      elem_mask = '1;
    endcase
  end
endmodule

// File: rtl/vseq_reg_step.sv
module vseq_reg_step #(
  parameter int RW = 7,
  parameter int IW = 6
) (
  input  logic [RW-1:0] base,
  input  logic          is_vec,
  input  logic [IW-1:0] idx,
  output logic [RW-1:0] reg_num
);
  logic [RW-1:0] offset;
  assign offset  = is_vec ? RW'(idx) : '0;
  assign reg_num = base + offset;
endmodule

// File: rtl/vseq_sign_code.sv
module vseq_sign_code #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] value,
  output logic [2:0]      code
);
  import vseq_pkg::*;

  always_comb begin
    if (value[XLEN-1])     code = CODE_NEG;
    else if (value == '0)  code = CODE_ZERO;
    else                   code = CODE_POS;
  end
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq #(
  parameter int XLEN   = 64,
  parameter int VL_MAX = 64,
  parameter int NREG   = 128,
  localparam int VLW   = $clog2(VL_MAX + 1),
  localparam int IW    = $clog2(VL_MAX),
  localparam int RW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VLW-1:0]    vl,
  input  logic [RW-1:0]     dst_base,
  input  logic [RW-1:0]     srca_base,
  input  logic [RW-1:0]     srcb_base,
  input  logic              dst_vec,
  input  logic              srca_vec,
  input  logic              srcb_vec,
  input  logic [2:0]        pred_sel,
  input  logic              rc_en,
  input  logic [XLEN-1:0]   int_mask,
  input  logic [VL_MAX-1:0] cr_eq,
  output logic              busy,
  output logic              done,
  output logic [RW-1:0]     rd_a_reg,
  output logic [RW-1:0]     rd_b_reg,
  input  logic [XLEN-1:0]   rd_a_data,
  input  logic [XLEN-1:0]   rd_b_data,
  output logic              wr_en,
  output logic [RW-1:0]     wr_reg,
  output logic [XLEN-1:0]   wr_data,
  output logic              cr_we,
  output logic [IW-1:0]     cr_field,
  output logic [2:0]        cr_val
);
  // control state
  logic           busy_q, busy_n;
  logic [IW-1:0]  idx_q, idx_n;
  logic           done_q, done_n;
  logic           cap_en;

  // captured instruction
  logic [VLW-1:0]    vl_q;
  logic [RW-1:0]     d_base_q, a_base_q, b_base_q;
  logic              d_vec_q, a_vec_q, b_vec_q;
  logic              rc_q;
  logic [VL_MAX-1:0] mask_q;

  logic [VL_MAX-1:0] mask_d;
  logic [VLW-1:0]    vl_clamped;
  logic              elem_en;
  logic              last_elem;
  logic [2:0]        sign_code;

  vseq_pred_mask #(.VL_MAX(VL_MAX), .XLEN(XLEN)) u_mask (
    .pred_sel (pred_sel),
    .int_mask (int_mask),
    .cr_eq    (cr_eq),
    .elem_mask(mask_d)
  );

  vseq_reg_step #(.RW(RW), .IW(IW)) u_step_d (
    .base(d_base_q), .is_vec(d_vec_q), .idx(idx_q), .reg_num(wr_reg)
  );
  vseq_reg_step #(.RW(RW), .IW(IW)) u_step_a (
    .base(a_base_q), .is_vec(a_vec_q), .idx(idx_q), .reg_num(rd_a_reg)
  );
  vseq_reg_step #(.RW(RW), .IW(IW)) u_step_b (
    .base(b_base_q), .is_vec(b_vec_q), .idx(idx_q), .reg_num(rd_b_reg)
  );

  assign wr_data = rd_a_data + rd_b_data;

  vseq_sign_code #(.XLEN(XLEN)) u_code (
    .value(wr_data),
    .code (sign_code)
  );

  assign vl_clamped = (vl > VLW'(VL_MAX)) ? VLW'(VL_MAX) : vl;
  assign elem_en    = mask_q[idx_q];
  assign last_elem  = ({1'b0, idx_q} + (IW+1)'(1)) == (IW+1)'(vl_q);

  // next-state logic
  always_comb begin
    busy_n = busy_q;
    idx_n  = idx_q;
    done_n = 1'b0;
    cap_en = 1'b0;
    if (!busy_q) begin
      if (start) begin
        cap_en = 1'b1;
        idx_n  = '0;
        if (vl == '0) done_n = 1'b1;
        else          busy_n = 1'b1;
      end
    end else begin
      if (last_elem || (elem_en && !d_vec_q)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end else begin
        idx_n = idx_q + IW'(1);
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      idx_q  <= idx_n;
      done_q <= done_n;
    end
  end

  // instruction capture, enabled at start only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q     <= '0;
      d_base_q <= '0;
      a_base_q <= '0;
      b_base_q <= '0;
      d_vec_q  <= 1'b0;
      a_vec_q  <= 1'b0;
      b_vec_q  <= 1'b0;
      rc_q     <= 1'b0;
      mask_q   <= '0;
    end else if (cap_en) begin
      vl_q     <= vl_clamped;
      d_base_q <= dst_base;
      a_base_q <= srca_base;
      b_base_q <= srcb_base;
      d_vec_q  <= dst_vec;
      a_vec_q  <= srca_vec;
      b_vec_q  <= srcb_vec;
      rc_q     <= rc_en;
      mask_q   <= mask_d;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign wr_en    = busy_q && elem_en;
  assign cr_we    = wr_en && rc_q;
  assign cr_field = idx_q;
  assign cr_val   = sign_code;
endmodule

// File: rtl/vec_elem_seq_chk.sv
module vec_elem_seq_chk #(
  parameter int VL_MAX = 64,
  parameter int RW     = 7,
  parameter int VLW    = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [VLW-1:0]    vl,
  input logic              busy,
  input logic              done,
  input logic              wr_en,
  input logic              cr_we,
  input logic [2:0]        cr_val,
  input logic [RW-1:0]     rd_a_reg,
  input logic [RW-1:0]     a_base_q,
  input logic              a_vec_q,
  input logic              d_vec_q,
  input logic [VL_MAX-1:0] mask_q
);
  assert_vl0_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && vl == '0) |=> (done && !wr_en && !cr_we));

  assert_scalar_src_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !a_vec_q) |-> (rd_a_reg == a_base_q));

  assert_code_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> ($countones(cr_val) == 1 && wr_en));

  assert_scalar_dst_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !d_vec_q) |=> (done && !busy));

  assert_write_only_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_mask_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mask_q));
endmodule

bind vec_elem_seq vec_elem_seq_chk #(.VL_MAX(VL_MAX), .RW(RW), .VLW(VLW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .vl       (vl),
  .busy     (busy),
  .done     (done),
  .wr_en    (wr_en),
  .cr_we    (cr_we),
  .cr_val   (cr_val),
  .rd_a_reg (rd_a_reg),
  .a_base_q (a_base_q),
  .a_vec_q  (a_vec_q),
  .d_vec_q  (d_vec_q),
  .mask_q   (mask_q)
);

// File: tb/vec_elem_seq_tb_top.sv
`timescale 1ns/1ps
module vec_elem_seq_tb_top;
  localparam int XLEN = 64;
  localparam int VLM  = 64;
  localparam int NR   = 128;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [6:0]       vl;
  logic [6:0]       dst_base, srca_base, srcb_base;
  logic             dst_vec, srca_vec, srcb_vec;
  logic [2:0]       pred_sel;
  logic             rc_en;
  logic [XLEN-1:0]  int_mask;
  logic [VLM-1:0]   cr_eq;
  logic             busy, done;
  logic [6:0]       rd_a_reg, rd_b_reg;
  logic [XLEN-1:0]  rd_a_data, rd_b_data;
  logic             wr_en;
  logic [6:0]       wr_reg;
  logic [XLEN-1:0]  wr_data;
  logic             cr_we;
  logic [5:0]       cr_field;
  logic [2:0]       cr_val;

  logic [XLEN-1:0]  rf     [NR];
  logic [XLEN-1:0]  exp_rf [NR];
  logic [2:0]       crf    [VLM];
  logic [2:0]       exp_cr [VLM];

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  assign rd_a_data = rf[rd_a_reg];
  assign rd_b_data = rf[rd_b_reg];

  vec_elem_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
    .dst_base(dst_base), .srca_base(srca_base), .srcb_base(srcb_base),
    .dst_vec(dst_vec), .srca_vec(srca_vec), .srcb_vec(srcb_vec),
    .pred_sel(pred_sel), .rc_en(rc_en), .int_mask(int_mask), .cr_eq(cr_eq),
    .busy(busy), .done(done), .rd_a_reg(rd_a_reg), .rd_b_reg(rd_b_reg),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .wr_en(wr_en),
    .wr_reg(wr_reg), .wr_data(wr_data), .cr_we(cr_we),
    .cr_field(cr_field), .cr_val(cr_val)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [2:0] code_of(input logic [XLEN-1:0] v);
    if (v[XLEN-1]) return 3'b100;
    if (v == '0)   return 3'b010;
    return 3'b001;
  endfunction

  function automatic bit enabled(input int sel, input int i,
                                 input logic [XLEN-1:0] m, input logic [VLM-1:0] c);
    case (sel)
      1: return m[i];
      2: return !m[i];
      3: return c[i];
      4: return !c[i];
      default: return 1'b1;
    endcase
  endfunction

  // one vector add, compared with a sequential element model
  task automatic run_op(input int nvl, input int d, input int a, input int b,
                        input bit dv, input bit av, input bit bv,
                        input int sel, input bit rc, input logic [VLM-1:0] crbits,
                        input string req);
    int exp_cycles, exp_writes, got_writes, cycles, di, ai, bi;
    logic [XLEN-1:0] m, s;
    bit ok;
    m = rf[30];
    foreach (rf[k]) exp_rf[k] = rf[k];
    foreach (crf[k]) exp_cr[k] = crf[k];
    exp_writes = 0;
    exp_cycles = 1;
    for (int i = 0; i < nvl; i++) begin
      exp_cycles = i + 2;
      if (enabled(sel, i, m, crbits)) begin
        di = (d + (dv ? i : 0)) % NR;
        ai = (a + (av ? i : 0)) % NR;
        bi = (b + (bv ? i : 0)) % NR;
        s  = exp_rf[ai] + exp_rf[bi];
        exp_rf[di] = s;
        if (rc) exp_cr[i] = code_of(s);
        exp_writes++;
        if (!dv) break;
      end
    end
    @(negedge clk);
    vl = 7'(nvl); dst_base = 7'(d); srca_base = 7'(a); srcb_base = 7'(b);
    dst_vec = dv; srca_vec = av; srcb_vec = bv; pred_sel = 3'(sel);
    rc_en = rc; int_mask = m; cr_eq = crbits; start = 1'b1;
    @(negedge clk);
    // scramble everything after capture (R11)
    vl = 7'($urandom_range(1, 64)); dst_base = 7'($urandom); srca_base = 7'($urandom);
    srcb_base = 7'($urandom); dst_vec = ~dv; srca_vec = ~av; srcb_vec = ~bv;
    pred_sel = 3'($urandom); rc_en = ~rc; int_mask = {$urandom, $urandom};
    cr_eq = ~crbits; start = 1'b1;
    cycles = 1;
    got_writes = 0;
    forever begin
      if (wr_en) begin rf[wr_reg] = wr_data; got_writes++; end
      if (cr_we) crf[cr_field] = cr_val;
      if (done) break;
      if (cycles > 200) begin
        check(1'b0, req, "sequence watchdog", cycles, exp_cycles);
        break;
      end
      @(negedge clk);
      start = 1'b0;
      cycles++;
    end
    start = 1'b0;
    ok = 1'b1;
    foreach (rf[k]) if (rf[k] !== exp_rf[k]) ok = 1'b0;
    check(ok, req, "register state (R2 R7)", 0, 1);
    ok = 1'b1;
    foreach (crf[k]) if (crf[k] !== exp_cr[k]) ok = 1'b0;
    check(ok, req, "condition fields (R8)", 0, 1);
    check(cycles == exp_cycles, req, "done cycle (R10)", cycles, exp_cycles);
    check(got_writes == exp_writes, req, "write count", got_writes, exp_writes);
    @(negedge clk);
    check(!done && !busy, req, "done one cycle (R10)", done, 0);
  endtask

  initial begin
    #400000;
    n_checks++;
    n_fail++;
    $display("FAIL global watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [VLM-1:0] cb;
    void'($urandom(32'h1234_5EED));
    rst_n = 1'b0; start = 1'b0; vl = '0; dst_base = '0; srca_base = '0; srcb_base = '0;
    dst_vec = 1'b0; srca_vec = 1'b0; srcb_vec = 1'b0; pred_sel = '0; rc_en = 1'b0;
    int_mask = '0; cr_eq = '0;
    for (int k = 0; k < NR; k++) rf[k] = {$urandom, $urandom};
    for (int k = 0; k < VLM; k++) crf[k] = 3'b000;
    repeat (3) @(negedge clk);
    check(!busy && !done && !wr_en && !cr_we, "R10", "reset outputs", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: zero length does nothing
    run_op(0, 1, 5, 9, 1, 1, 1, 0, 1, '1, "R1");
    // R6: unpredicated vector add with record, zero and negative sums (R8)
    rf[5] = 64'hFFFF_FFFF_FFFF_FFFF; rf[9] = 64'd1;
    rf[6] = 64'h8000_0000_0000_0000; rf[10] = 64'd5;
    rf[7] = 64'd3; rf[11] = 64'd4;
    run_op(3, 1, 5, 9, 1, 1, 1, 0, 1, '0, "R8");
    // R3: integer mask 0b101
    rf[30] = 64'h5;
    run_op(3, 1, 5, 9, 1, 1, 1, 1, 0, '0, "R3");
    // R4: inverted integer mask
    run_op(3, 13, 10, 7, 1, 1, 1, 2, 0, '0, "R4");
    // R6: all-zero and all-one integer masks
    rf[30] = '0;
    run_op(3, 1, 5, 9, 1, 1, 1, 1, 0, '0, "R6");
    rf[30] = '1;
    run_op(3, 1, 5, 9, 1, 1, 1, 1, 0, '0, "R6");
    // R5: CR EQ and its inverse
    run_op(2, 1, 5, 9, 1, 1, 1, 3, 0, 64'h2, "R5");
    run_op(2, 1, 5, 9, 1, 1, 1, 4, 0, 64'h1, "R5");
    // R2: scalar source with vector source
    run_op(4, 20, 5, 9, 1, 0, 1, 0, 0, '0, "R2");
    // R9: scalar destination, first element skipped, stops at second
    rf[30] = 64'h6;
    run_op(4, 1, 5, 9, 0, 1, 1, 1, 1, '0, "R9");
    // R2 wrap and R10 full length
    run_op(64, 100, 90, 70, 1, 1, 1, 0, 0, '0, "R10");
    // R7: carry-out wraps
    rf[40] = 64'hFFFF_FFFF_FFFF_FFF0; rf[41] = 64'h20;
    run_op(1, 42, 40, 41, 1, 1, 1, 0, 0, '0, "R7");

    // constrained random mix (R2 to R11)
    for (int t = 0; t < 60; t++) begin
      cb = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) rf[30] = {$urandom, $urandom};
      run_op(($urandom_range(0, 7) == 0) ? $urandom_range(0, 64) : $urandom_range(0, 10),
             $urandom_range(0, 127), $urandom_range(0, 127), $urandom_range(0, 127),
             1'($urandom), 1'($urandom), 1'($urandom), $urandom_range(0, 7),
             1'($urandom), cb, "R11");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule